// File: doc/BRIEF.md
# Sync-Triggered Timing Core Start Controller

This block brings up the horizontal and vertical counters of a video timing generator. After reset the core stays idle until software sets a run bit. The core then waits for a qualified sync event: the effective sync line must stay low for a minimum time and then go high again. On that rising edge the pixel and line counters clear, and the core starts to produce one-cycle line strobes (HD) and frame strobes (VD). When master mode is selected, both strobes are driven out of the block.

The gated pixel clock output and the data outputs stay at zero until an output-enable bit is applied. Software arms that bit at any time, but it only takes effect on a line strobe. Because line strobes exist only once the counters are running, enabling the outputs always waits for a sync event.

A divide-by-two option halves the pixel rate when the input clock runs at twice the pixel frequency. That option is captured only while the core is held idle. Systems with no external sync can create a sync event by writing the polarity-inversion bit: set it while the line is high, hold it for the minimum time, then clear it.

Top module: `tg_start_ctrl`

## Requirements
- R1: While `cfg_core_run` is 0, the core is held. `hd_o`, `vd_o` and `out_active_o` are 0 from the next cycle on, and no sync activity starts the counters.
- R2: The effective sync is `sync_in XOR cfg_sync_inv`. A sync event happens only when this signal is sampled low on at least LOW_CYC consecutive clock edges and then sampled high. LOW_CYC is the ceiling of MIN_SYNC_LOW_PS / CLK_PERIOD_PS, which is 10 with the defaults. A shorter low time is ignored.
- R3: In the cycle right after the clock edge that sees the qualifying rise, the pixel and line counters are both zero. `hd_o` and `vd_o` are both 1 in that cycle, provided master mode is set.
- R4: HD strobes repeat every H_PIX pixel ticks. A VD strobe coincides with every V_LINES-th HD strobe, and VD never appears without HD.
- R5: With `cfg_clk_div2` captured as 1, a pixel tick occurs every second clock, so the HD period is 2*H_PIX clocks. The divider setting is captured only while `cfg_core_run` is 0. Changes made while the core runs are ignored.
- R6: `out_active_o` takes the value of `cfg_out_en` only on a cycle that carries an HD strobe. The new value shows in the next cycle. While `out_active_o` is 0, `pclk_o` and `data_o` are 0. While it is 1, `data_o` equals `data_i`.
- R7: With `sync_in` held high, setting `cfg_sync_inv` to 1 for at least LOW_CYC clocks and then clearing it produces a sync event that starts the counters.
- R8: With `cfg_master` at 0, `hd_o` and `vd_o` stay 0. The counters and the output-enable update keep running.
- R9: A qualified sync event while the counters already run restarts them. The cycle after the event carries HD and VD.
- R10: While active, `pclk_o` toggles on every pixel tick. Its phase is 0 in the first cycle after a sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (pixel rate or twice pixel rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_core_run | input | 1 | Releases the timing core from its held state |
| cfg_clk_div2 | input | 1 | Selects one pixel tick per two clocks; captured while held |
| cfg_master | input | 1 | Drives HD/VD strobes out of the block |
| cfg_out_en | input | 1 | Armed output enable, applied on an HD strobe |
| cfg_sync_inv | input | 1 | Inverts the sync input; toggling it makes an internal event |
| sync_in | input | 1 | External sync line |
| data_i | input | DATA_W | Pixel data to be gated |
| hd_o | output | 1 | One-clock line strobe |
| vd_o | output | 1 | One-clock frame strobe |
| pclk_o | output | 1 | Gated pixel clock phase |
| data_o | output | DATA_W | Gated pixel data |
| out_active_o | output | 1 | Outputs currently enabled |

## Verification
A wrong qualification count shows as an HD/VD pair appearing one cycle after a sync pulse that is too short, or as no pair after one that is long enough. Either error is visible on the first cycle after the rising edge. A pixel or line counter that is off by one moves the next HD, or the next VD, by a cycle within one line or one frame. A stale divider capture doubles or halves the HD spacing from the very first line. An enable applied outside an HD strobe changes `out_active_o`, `pclk_o` and `data_o` in a cycle where the per-clock reference model still expects them unchanged.

// File: rtl/tg_start_pkg.sv
// Package: shared helpers for the timing core start controller.
// Assumes: all arguments are positive integers.
package tg_start_pkg;

    // Integer ceiling division used for cycle-count thresholds.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/tg_sync_qualifier.sv
// Module: tg_sync_qualifier
// Measures how long the effective sync line stays low and flags a sync event on
// a rise that follows at least LOW_CYC low samples.
// Assumes: sync_in is already synchronous to clk. Qualification runs only while
// the core is released.
module tg_sync_qualifier #(
    parameter int unsigned LOW_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_run,
    input  logic sync_in,
    input  logic sync_inv,
    output logic sync_evt
);
    localparam int unsigned CW = $clog2(LOW_CYC + 1);

    logic          eff;
    logic          prev_q;
    logic [CW-1:0] low_cnt_q;

    assign eff      = sync_in ^ sync_inv;
    assign sync_evt = core_run & eff & ~prev_q & (low_cnt_q >= CW'(LOW_CYC));

    // Saturating low-time counter plus previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run) begin
            low_cnt_q <= '0;
            prev_q    <= 1'b1;
        end else begin
            prev_q <= eff;
            if (eff)
                low_cnt_q <= '0;
            else if (low_cnt_q != CW'(LOW_CYC))
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    p_low_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= CW'(LOW_CYC));

    p_evt_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |-> ($past(eff) == 1'b0 && $past(core_run)));

endmodule

// File: rtl/tg_line_frame_counter.sv
// Module: tg_line_frame_counter
// Runs the pixel and line counters from the first sync event on and emits
// one-clock HD and VD strobes. A captured divide-by-two makes a pixel tick
// every other clock.
// Assumes: H_PIX >= 2 and V_LINES >= 2.
module tg_line_frame_counter #(
    parameter int unsigned H_PIX   = 12,
    parameter int unsigned V_LINES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_run,
    input  logic div_req,
    input  logic sync_evt,
    output logic hd_stb_o,
    output logic vd_stb_o,
    output logic pclk_ph_o
);
    localparam int unsigned HW = $clog2(H_PIX);
    localparam int unsigned VW = $clog2(V_LINES);

    logic          running_q;
    logic          div_q;
    logic          phase_q;
    logic          pclk_q;
    logic          tick;
    logic [HW-1:0] pix_q;
    logic [VW-1:0] line_q;

    assign tick      = running_q & (~div_q | phase_q);
    assign hd_stb_o  = tick & (pix_q == '0);
    assign vd_stb_o  = hd_stb_o & (line_q == '0);
    assign pclk_ph_o = pclk_q;

    // Capture the clock-divide choice only while the core is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= 1'b0;
        else if (!core_run)
            div_q <= div_req;
    end

    // Run flag: set by the first sync event, cleared when the core is held.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run)
            running_q <= 1'b0;
        else if (sync_evt)
            running_q <= 1'b1;
    end

    // Divider phase: forced to tick right after a sync event.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run)
            phase_q <= 1'b0;
        else if (sync_evt)
            phase_q <= 1'b1;
        else if (running_q)
            phase_q <= ~phase_q;
    end

    // Pixel and line counters with wrap at the parameterized limits.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (sync_evt) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (tick) begin
            if (pix_q == HW'(H_PIX - 1)) begin
                pix_q  <= '0;
                line_q <= (line_q == VW'(V_LINES - 1)) ? '0 : line_q + 1'b1;
            end else begin
                pix_q <= pix_q + 1'b1;
            end
        end
    end

    // Pixel clock phase toggles once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run || sync_evt)
            pclk_q <= 1'b0;
        else if (tick)
            pclk_q <= ~pclk_q;
    end

    p_pix_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_q < HW'(H_PIX));

    p_vd_with_hd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vd_stb_o |-> hd_stb_o);

    p_evt_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> (pix_q == '0 && line_q == '0 && running_q));

    p_div_alternates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q && tick && !sync_evt) |=> !tick);

endmodule

// File: rtl/tg_output_gate.sv
// Module: tg_output_gate
// Holds the active output-enable state, which is loaded from the armed enable
// bit only on HD strobes. Forces the clock and data outputs to zero while
// inactive.
// Assumes: hd_stb is a one-clock strobe from the counter.
module tg_output_gate #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_run,
    input  logic              hd_stb,
    input  logic              out_en_req,
    input  logic              pclk_ph,
    input  logic [DATA_W-1:0] data_i,
    output logic              active_o,
    output logic              pclk_o,
    output logic [DATA_W-1:0] data_o
);
    logic active_q;

    // Apply the armed enable at a line strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_run)
            active_q <= 1'b0;
        else if (hd_stb)
            active_q <= out_en_req;
    end

    assign active_o = active_q;
    assign pclk_o   = active_q & pclk_ph;
    assign data_o   = active_q ? data_i : '0;

    p_enable_at_hd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(hd_stb));

    p_disable_at_hd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_q) && $past(core_run)) |-> $past(hd_stb));

endmodule

// File: rtl/tg_start_ctrl.sv
// Module: tg_start_ctrl (top)
// Wires sync qualification, the line/frame counters and the output gate together.
// Master mode decides whether the strobes leave the block.
// Assumes: all cfg_* bits are static register outputs in the clk domain.
module tg_start_ctrl #(
    parameter int unsigned CLK_PERIOD_PS   = 10000,
    parameter int unsigned MIN_SYNC_LOW_PS = 100000,
    parameter int unsigned H_PIX           = 12,
    parameter int unsigned V_LINES         = 5,
    parameter int unsigned DATA_W          = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_core_run,
    input  logic              cfg_clk_div2,
    input  logic              cfg_master,
    input  logic              cfg_out_en,
    input  logic              cfg_sync_inv,
    input  logic              sync_in,
    input  logic [DATA_W-1:0] data_i,
    output logic              hd_o,
    output logic              vd_o,
    output logic              pclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              out_active_o
);
    localparam int unsigned LOW_CYC = tg_start_pkg::ceil_div(MIN_SYNC_LOW_PS, CLK_PERIOD_PS);

    logic sync_evt;
    logic hd_stb;
    logic vd_stb;
    logic pclk_ph;

    tg_sync_qualifier #(.LOW_CYC(LOW_CYC)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_run (cfg_core_run),
        .sync_in  (sync_in),
        .sync_inv (cfg_sync_inv),
        .sync_evt (sync_evt)
    );

    tg_line_frame_counter #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_run  (cfg_core_run),
        .div_req   (cfg_clk_div2),
        .sync_evt  (sync_evt),
        .hd_stb_o  (hd_stb),
        .vd_stb_o  (vd_stb),
        .pclk_ph_o (pclk_ph)
    );

    tg_output_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_run   (cfg_core_run),
        .hd_stb     (hd_stb),
        .out_en_req (cfg_out_en),
        .pclk_ph    (pclk_ph),
        .data_i     (data_i),
        .active_o   (out_active_o),
        .pclk_o     (pclk_o),
        .data_o     (data_o)
    );

    // Strobes leave the block only in master mode.
    assign hd_o = hd_stb & cfg_master;
    assign vd_o = vd_stb & cfg_master;

    p_held_core_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_core_run |=> (!hd_o && !vd_o && !out_active_o));

endmodule

// File: tb/tg_start_ctrl_tb.sv
module tg_start_ctrl_tb_top;
    localparam int H    = 12;
    localparam int V    = 5;
    localparam int DW   = 12;
    localparam int LOWC = (100000 + 10000 - 1) / 10000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_core_run = 1'b0, cfg_clk_div2 = 1'b0, cfg_master = 1'b0;
    logic          cfg_out_en = 1'b0, cfg_sync_inv = 1'b0, sync_in = 1'b1;
    logic [DW-1:0] data_i = '0;
    logic          hd_o, vd_o, pclk_o, out_active_o;
    logic [DW-1:0] data_o;

    int    n_checks = 0, n_fail = 0, cycles = 0;
    string cur_tag = "R1";
    bit    primed = 1'b0;

    // Behavioural reference state.
    int m_low = 0, m_prev = 1, m_run = 0, m_div = 0, m_ph = 0;
    int m_pix = 0, m_line = 0, m_pclk = 0, m_act = 0;

    always #5 clk = ~clk;

    tg_start_ctrl #(.CLK_PERIOD_PS(10000), .MIN_SYNC_LOW_PS(100000),
                    .H_PIX(H), .V_LINES(V), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_core_run(cfg_core_run),
        .cfg_clk_div2(cfg_clk_div2), .cfg_master(cfg_master),
        .cfg_out_en(cfg_out_en), .cfg_sync_inv(cfg_sync_inv),
        .sync_in(sync_in), .data_i(data_i), .hd_o(hd_o), .vd_o(vd_o),
        .pclk_o(pclk_o), .data_o(data_o), .out_active_o(out_active_o)
    );

    task automatic cmp(input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        bit eff, rise, tick, hd;
        cycles++;
        eff = sync_in ^ cfg_sync_inv;
        if (!rst_n || !cfg_core_run) begin
            m_low = 0; m_prev = 1; m_run = 0; m_ph = 0; m_pix = 0;
            m_line = 0; m_pclk = 0; m_act = 0;
            m_div = rst_n ? int'(cfg_clk_div2) : 0;
        end else begin
            rise = eff && m_prev == 0 && m_low >= LOWC;
            tick = m_run != 0 && (m_div == 0 || m_ph != 0);
            hd   = tick && m_pix == 0;
            if (hd) m_act = int'(cfg_out_en);
            if (rise) begin
                m_run = 1; m_ph = 1; m_pix = 0; m_line = 0; m_pclk = 0;
            end else if (m_run != 0) begin
                m_ph = 1 - m_ph;
                if (tick) begin
                    m_pclk = 1 - m_pclk;
                    if (m_pix == H - 1) begin
                        m_pix = 0;
                        m_line = (m_line == V - 1) ? 0 : m_line + 1;
                    end else m_pix++;
                end
            end
            m_low  = eff ? 0 : ((m_low < LOWC) ? m_low + 1 : m_low);
            m_prev = int'(eff);
        end
        primed = 1'b1;
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) if (primed) begin
        bit tick, hd, vd;
        tick = m_run != 0 && (m_div == 0 || m_ph != 0);
        hd   = tick && m_pix == 0;
        vd   = hd && m_line == 0;
        cmp("hd_o (R4)", hd_o, hd && cfg_master);
        cmp("vd_o (R4)", vd_o, vd && cfg_master);
        cmp("out_active_o (R6)", out_active_o, m_act);
        cmp("pclk_o (R10)", pclk_o, (m_act != 0) && (m_pclk != 0));
        cmp("data_o (R6)", data_o, (m_act != 0) ? data_i : 0);
    end

    // Free-running pixel data.
    initial forever begin
        @(posedge clk); #2;
        data_i = data_i + 1'b1;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        wait (cycles > 60000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 60000);
        report();
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic count_strobes(input int n, output int hdc, output int vdc);
        hdc = 0; vdc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hd_o) hdc++;
            if (vd_o) vdc++;
        end
    endtask

    task automatic sync_pulse(input int lowcyc);
        sync_in = 1'b0;
        repeat (lowcyc) step();
        sync_in = 1'b1;
    endtask

    initial begin
        int hc, vc;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1: reset state and a held core ignoring sync.
        cur_tag = "R1";
        cmp("R1 out_active_o after reset", out_active_o, 0);
        cmp("R1 hd_o after reset", hd_o, 0);
        sync_pulse(15);
        count_strobes(20, hc, vc);
        cmp("R1 strobes while held", hc, 0);

        // R2: a short low pulse is rejected.
        step();
        cfg_core_run = 1'b1; cfg_master = 1'b1; cfg_out_en = 1'b1;
        step();
        cur_tag = "R2";
        sync_pulse(LOWC - 1);
        count_strobes(30, hc, vc);
        cmp("R2 strobes after short pulse", hc, 0);

        // R3: a qualified pulse starts the counters with HD and VD together.
        step();
        cur_tag = "R3";
        sync_pulse(LOWC);
        @(posedge clk); @(negedge clk);
        cmp("R3 first hd_o", hd_o, 1);
        cmp("R3 first vd_o", vd_o, 1);
        step();
        cmp("R6 enable applied at first HD", out_active_o, 1);

        // R4: HD period H, VD every V lines.
        cur_tag = "R4";
        count_strobes(2 * H * V, hc, vc);
        cmp("R4 hd count over two frames", hc, 2 * V);
        cmp("R4 vd count over two frames", vc, 2);

        // R6: disable takes effect at the next HD; outputs forced to zero.
        step();
        cur_tag = "R6";
        cfg_out_en = 1'b0;
        repeat (30) step();
        cmp("R6 out_active_o disabled", out_active_o, 0);
        cmp("R6 data_o gated", data_o, 0);
        cmp("R10 pclk_o gated", pclk_o, 0);
        cfg_out_en = 1'b1;
        repeat (15) step();

        // R8: slave mode keeps the strobes off the outputs.
        cur_tag = "R8";
        cfg_master = 1'b0;
        count_strobes(30, hc, vc);
        cmp("R8 hd_o in slave mode", hc, 0);
        step();
        cfg_master = 1'b1;
        repeat (5) step();

        // R9: a sync event mid-line restarts the counters.
        cur_tag = "R9";
        sync_pulse(LOWC);
        @(posedge clk); @(negedge clk);
        cmp("R9 hd_o after restart", hd_o, 1);
        cmp("R9 vd_o after restart", vd_o, 1);

        // R1/R5: hold, select divide-by-two, release again.
        step();
        cur_tag = "R1";
        cfg_core_run = 1'b0; cfg_clk_div2 = 1'b1;
        repeat (5) step();
        cmp("R1 held core inactive", out_active_o, 0);
        cfg_core_run = 1'b1;
        step();

        // R7: internal sync via polarity toggle; R5 halved pixel rate.
        cur_tag = "R7";
        cfg_sync_inv = 1'b1;
        repeat (LOWC) step();
        cfg_sync_inv = 1'b0;
        count_strobes(4 * H, hc, vc);
        cmp("R7 internal sync started core (R5 two lines in 4H clocks)", hc, 2);

        // R5: divider change while running is ignored.
        step();
        cur_tag = "R5";
        cfg_clk_div2 = 1'b0;
        count_strobes(8 * H, hc, vc);
        cmp("R5 hd count unchanged after live divider write", hc, 4);
        step();
        report();
    end
endmodule